// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only word cache that sits between a processor load port and a slower memory. It holds 1024 one-word entries arranged as 512 sets of two ways. Each lookup takes the set number from the middle address bits, compares the stored tags of both ways of that set in parallel, and returns the word in the same cycle when either way matches. The word is steered to the output by a two-input select that is driven by the hit decision, so no data leaves the block before the match is resolved.

Each set has a single replacement bit that names the way to evict next. Every hit and every fill points that bit at the other way. On a miss the processor is stalled: the block raises a memory request for the word-aligned address, waits for the memory to answer, writes the word into the chosen way and then hands the word to the processor. An empty way is always used before an occupied one. With two ways, two addresses that share a set can both stay resident, so alternating between them stops missing once both are loaded.

Top module: `cache2w_top`

## Requirements
- R1: Address bits [1:0] are a byte offset that plays no part in the lookup, bits [10:2] select one of 512 sets, and bits [31:11] form the 21-bit tag; two addresses that differ only in bits [1:0] hit the same entry.
- R2: After reset every entry is empty: `cpu_rdy_o`, `cpu_hit_o` and `mem_req_o` are low and the first lookup of any address misses.
- R3: When `cpu_req_i` is high and the addressed word is resident, `cpu_rdy_o` and `cpu_hit_o` are high in that same cycle and `cpu_data_o` carries the stored word.
- R4: On a miss, `mem_req_o` rises one cycle later with `mem_addr_o` equal to the request address with bits [1:0] cleared, and it stays high with a stable address until `mem_rdy_i` is seen; `cpu_rdy_o` stays low the whole time.
- R5: One cycle after the cycle in which `mem_req_o` and `mem_rdy_i` are both high, `cpu_rdy_o` is high, `cpu_hit_o` is low and `cpu_data_o` equals the `mem_data_i` value of the fill cycle.
- R6: Starting with empty sets, alternating eight times between two addresses with the same set and different tags gives exactly two misses.
- R7: A miss fills an empty way of the set before any occupied one, so the second distinct tag of a set never evicts the first.
- R8: When both ways are occupied, a miss replaces the way that was referenced (by hit or fill) less recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_i | input | 1 | Processor read request, held until `cpu_rdy_o` |
| cpu_addr_i | input | 32 | Processor byte address, held with the request |
| cpu_rdy_o | output | 1 | Read data valid, completes the request |
| cpu_hit_o | output | 1 | High with `cpu_rdy_o` when the word was resident |
| cpu_data_o | output | 32 | Read word, zero when `cpu_rdy_o` is low |
| mem_req_o | output | 1 | Memory word read request during a fill |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_rdy_i | input | 1 | Memory returns the word this cycle |
| mem_data_i | input | 32 | Memory read word |

## Verification
The properties assume that the processor keeps `cpu_req_i` high and `cpu_addr_i` unchanged from the start of a request until the cycle in which `cpu_rdy_o` is seen, since the memory address check compares against the live request address. They also assume the memory raises `mem_rdy_i` only while `mem_req_o` is high. The stimulus holds every request through its miss, drives the memory answer only after seeing the request and after a random wait of zero to three cycles, and drops the request in the cycle after completion; random addresses are drawn from a few sets and tags so that both ways fill and evictions happen often.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  // Controller phases of one processor request
  typedef enum logic [1:0] {
    ST_LOOK  = 2'd0,   // compare tags, answer hits
    ST_FETCH = 2'd1,   // memory read outstanding
    ST_RESP  = 2'd2    // hand the filled word to the processor
  } cstate_e;

  // Way to fill on a miss: empty ways first, otherwise the replacement bit
  function automatic logic pick_victim(input logic v0, input logic v1, input logic repl);
    logic w;
    if (!v0)      w = 1'b0;
    else if (!v1) w = 1'b1;
    else          w = repl;
    return w;
  endfunction

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SETS   = 512,
  parameter int IDX_W  = 9,
  parameter int TAG_W  = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [SETS-1:0]   valid_q, valid_d;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Tag and data arrays carry no reset; the valid bit guards them
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

endmodule

// File: rtl/cache2w_repl.sv
module cache2w_repl #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_evict,   // way to replace next in rd_idx
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way     // way just referenced
);

  logic [SETS-1:0] evict_q, evict_d;

  always_comb begin
    evict_d = evict_q;
    if (upd_en) evict_d[upd_idx] = ~upd_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evict_q <= '0;
    else        evict_q <= evict_d;
  end

  assign rd_evict = evict_q[rd_idx];

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tag_match,
  input  logic mem_ack,
  output logic in_look,
  output logic in_fetch,
  output logic in_resp,
  output logic miss_start,
  output logic fill_we
);

  cstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOK:  if (req && !tag_match) state_d = ST_FETCH;
      ST_FETCH: if (mem_ack)           state_d = ST_RESP;
      ST_RESP:                         state_d = ST_LOOK;
      default:                         state_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOOK;
    else        state_q <= state_d;
  end

  assign in_look    = (state_q == ST_LOOK);
  assign in_fetch   = (state_q == ST_FETCH);
  assign in_resp    = (state_q == ST_RESP);
  assign miss_start = in_look && req && !tag_match;
  assign fill_we    = in_fetch && mem_ack;

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 512,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_rdy_o,
  output logic              cpu_hit_o,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rdy_i,
  input  logic [DATA_W-1:0] mem_data_i
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFFS_W;
  localparam int NWAY  = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address fields of the live request and of the latched miss
  logic [IDX_W-1:0]  req_idx, miss_idx;
  logic [TAG_W-1:0]  req_tag, miss_tag;
  logic [ADDR_W-1:0] miss_addr_q, miss_addr_d;
  logic              vict_q, vict_d;
  logic [DATA_W-1:0] fill_q, fill_d;

  assign req_idx  = cpu_addr_i[OFFS_W +: IDX_W];
  assign req_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign miss_idx = miss_addr_q[OFFS_W +: IDX_W];
  assign miss_tag = miss_addr_q[ADDR_W-1 -: TAG_W];

  // Control
  logic in_look, in_fetch, in_resp, miss_start, fill_we;
  logic any_match;

  cache2w_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (cpu_req_i),
    .tag_match  (any_match),
    .mem_ack    (mem_rdy_i),
    .in_look    (in_look),
    .in_fetch   (in_fetch),
    .in_resp    (in_resp),
    .miss_start (miss_start),
    .fill_we    (fill_we)
  );

  // Ways: parallel read and compare
  logic [NWAY-1:0]   way_valid;
  logic [NWAY-1:0]   way_match;
  logic [TAG_W-1:0]  way_tag  [NWAY];
  logic [DATA_W-1:0] way_data [NWAY];

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    logic wr_this;
    assign wr_this = fill_we && (vict_q == w[0]);

    cache2w_way #(
      .SETS   (SETS),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) i_way (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .rd_idx   (req_idx),
      .rd_valid (way_valid[w]),
      .rd_tag   (way_tag[w]),
      .rd_data  (way_data[w]),
      .wr_en    (wr_this),
      .wr_idx   (miss_idx),
      .wr_tag   (miss_tag),
      .wr_data  (mem_data_i)
    );

    assign way_match[w] = way_valid[w] && (way_tag[w] == req_tag);
  end

  assign any_match = |way_match;

  // Replacement state
  logic evict_way;
  logic repl_en, repl_way;
  logic [IDX_W-1:0] repl_idx;
  logic look_hit;

  assign look_hit = in_look && cpu_req_i && any_match;
  assign repl_en  = look_hit || fill_we;
  assign repl_idx = look_hit ? req_idx : miss_idx;
  assign repl_way = look_hit ? way_match[1] : vict_q;

  cache2w_repl #(
    .SETS  (SETS),
    .IDX_W (IDX_W)
  ) i_repl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_idx   (req_idx),
    .rd_evict (evict_way),
    .upd_en   (repl_en),
    .upd_idx  (repl_idx),
    .upd_way  (repl_way)
  );

  // Miss bookkeeping: next state
  always_comb begin
    miss_addr_d = miss_addr_q;
    vict_d      = vict_q;
    fill_d      = fill_q;
    if (miss_start) begin
      miss_addr_d = {cpu_addr_i[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
      vict_d      = pick_victim(way_valid[0], way_valid[1], evict_way);
    end
    if (fill_we) fill_d = mem_data_i;
  end

  // Miss bookkeeping: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      miss_addr_q <= '0;
      vict_q      <= 1'b0;
      fill_q      <= '0;
    end else begin
      miss_addr_q <= miss_addr_d;
      vict_q      <= vict_d;
      fill_q      <= fill_d;
    end
  end

  // Output select follows the hit decision
  logic [DATA_W-1:0] hit_word;
  assign hit_word = way_match[1] ? way_data[1] : way_data[0];

  always_comb begin
    cpu_data_o = '0;
    if (in_resp)       cpu_data_o = fill_q;
    else if (look_hit) cpu_data_o = hit_word;
  end

  assign cpu_rdy_o  = look_hit || in_resp;
  assign cpu_hit_o  = look_hit;
  assign mem_req_o  = in_fetch;
  assign mem_addr_o = miss_addr_q;

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_rdy_o,
  input logic              cpu_hit_o,
  input logic [DATA_W-1:0] cpu_data_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rdy_i,
  input logic [DATA_W-1:0] mem_data_i
);

  // R3: a hit answers only a live request and completes it
  a_r3_hit_completes: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit_o |-> (cpu_rdy_o && cpu_req_i));

  // R4: waiting request keeps its address until memory answers
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R4: processor stalled while the fill is outstanding
  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !cpu_rdy_o);

  // R4: word aligned address of the pending request
  a_r4_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && mem_addr_o[ADDR_W-1:2] == cpu_addr_i[ADDR_W-1:2]));

  // R5: fill answers the processor next cycle as a miss
  a_r5_fill_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> (cpu_rdy_o && !cpu_hit_o && !mem_req_o));

  // R5: returned word is the word memory delivered
  a_r5_fill_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> (cpu_data_o == $past(mem_data_i)));

  // R2: idle output word is zero
  a_r2_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdy_o |-> (cpu_data_o == '0));

endmodule

bind cache2w_top cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_cache2w_top.sv
module test_cache2w_top;

  logic        clk;
  logic        rst_n;
  logic        cpu_req_i;
  logic [31:0] cpu_addr_i;
  logic        cpu_rdy_o;
  logic        cpu_hit_o;
  logic [31:0] cpu_data_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rdy_i;
  logic [31:0] mem_data_i;

  int n_chk  = 0;
  int n_fail = 0;
  int n_miss = 0;
  int cyc    = 0;
  bit done   = 0;

  // Bench model of the cache contents
  bit        mv  [2][512];
  bit [20:0] mt  [2][512];
  bit        mev [512];

  cache2w_top i_cache2w_top (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic [31:0] mem_word(input [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string rq, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  // One read request; returns 1 on hit. Checks against the model.
  task automatic access(input [31:0] a, input string rq, output bit was_hit);
    bit [8:0]  idx;
    bit [20:0] tg;
    int        hw;
    bit        v;
    bit [31:0] word;
    int        lat;
    idx  = a[10:2];
    tg   = a[31:11];
    word = mem_word({a[31:2], 2'b00});
    hw   = -1;
    if (mv[0][idx] && mt[0][idx] == tg) hw = 0;
    else if (mv[1][idx] && mt[1][idx] == tg) hw = 1;
    @(negedge clk);
    cpu_req_i  = 1'b1;
    cpu_addr_i = a;
    #1;
    was_hit = cpu_hit_o;
    chk(cpu_hit_o == (hw >= 0), rq, {31'd0, cpu_hit_o}, {31'd0, hw >= 0});
    if (hw >= 0) begin
      // R3 same-cycle hit data
      chk(cpu_rdy_o && cpu_data_o == word, "R3", cpu_data_o, word);
      mev[idx] = ~hw[0];
    end else begin
      n_miss++;
      chk(!cpu_rdy_o, "R4", {31'd0, cpu_rdy_o}, 32'd0);
      @(negedge clk);
      chk(mem_req_o && mem_addr_o == {a[31:2], 2'b00}, "R4", mem_addr_o, {a[31:2], 2'b00});
      lat = int'($urandom_range(3, 0));
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(mem_req_o && !cpu_rdy_o, "R4", {30'd0, mem_req_o, cpu_rdy_o}, 32'd2);
      end
      mem_rdy_i  = 1'b1;
      mem_data_i = word;
      @(negedge clk);
      mem_rdy_i  = 1'b0;
      mem_data_i = 32'hDEAD_BEEF;
      #1;
      chk(cpu_rdy_o && !cpu_hit_o && cpu_data_o == word, "R5", cpu_data_o, word);
      // R7/R8 model: empty way first, then the replacement bit
      if (!mv[0][idx]) v = 1'b0;
      else if (!mv[1][idx]) v = 1'b1;
      else v = mev[idx];
      mv[v][idx] = 1'b1;
      mt[v][idx] = tg;
      mev[idx]   = ~v;
    end
    @(negedge clk);
    cpu_req_i = 1'b0;
  endtask

  initial begin
    bit h;
    int m0;
    void'($urandom(32'd7321));
    rst_n      = 1'b0;
    cpu_req_i  = 1'b0;
    cpu_addr_i = '0;
    mem_rdy_i  = 1'b0;
    mem_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    chk(!cpu_rdy_o && !cpu_hit_o && !mem_req_o, "R2",
        {29'd0, cpu_rdy_o, cpu_hit_o, mem_req_o}, 32'd0);
    access(32'h0000_0000, "R2", h);
    chk(!h, "R2", {31'd0, h}, 32'd0);
    access(32'h0000_0000, "R3", h);
    chk(h, "R3", {31'd0, h}, 32'd1);

    // R6 alternating pair in set 1
    m0 = n_miss;
    for (int i = 0; i < 8; i++) access((i % 2 == 0) ? 32'h0000_0004 : 32'h0000_0804, "R6", h);
    chk(n_miss - m0 == 2, "R6", n_miss - m0, 32'd2);

    // R1 byte offset ignored, top tag bit matters
    access(32'h0000_0807, "R1", h);
    chk(h, "R1", {31'd0, h}, 32'd1);
    access(32'h8000_0004, "R1", h);
    chk(!h, "R1", {31'd0, h}, 32'd0);

    // R7 second tag goes to the empty way
    access(32'h0000_0008, "R7", h);
    access(32'h0000_1008, "R7", h);
    access(32'h0000_0008, "R7", h);
    chk(h, "R7", {31'd0, h}, 32'd1);
    access(32'h0000_1008, "R7", h);
    chk(h, "R7", {31'd0, h}, 32'd1);

    // R8 A,B,A then C evicts B
    access(32'h0000_000C, "R8", h);
    access(32'h0000_080C, "R8", h);
    access(32'h0000_000C, "R8", h);
    access(32'h0000_100C, "R8", h);
    chk(!h, "R8", {31'd0, h}, 32'd0);
    access(32'h0000_000C, "R8", h);
    chk(h, "R8", {31'd0, h}, 32'd1);
    access(32'h0000_080C, "R8", h);
    chk(!h, "R8", {31'd0, h}, 32'd0);

    // Random mix over a few sets and tags
    for (int i = 0; i < 400; i++) begin
      bit [31:0] a;
      a = {19'd0, 2'($urandom_range(3, 0)), 9'($urandom_range(7, 0)), 2'($urandom_range(3, 0))};
      access(a, "R8", h);
    end

    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end

endmodule